// File: doc/BRIEF.md
# Interrupt Source Control Unit

This block keeps the interrupt state for a small group of interrupt sources inside an I/O controller, such as ports and counter/timers. Each source has four flags: pending, enable, under-service and error. A host changes the flags only by writing a 3-bit command into an 8-bit command/status byte. The host reads the flags back from a status byte. Raw event pulses set the pending flag. A second event that arrives while pending is already set raises the error flag.

The sources form a daisy chain in fixed priority order, with source 0 the highest. A source passes the chain enable down only while it is neither requesting nor under service. A master enable gates every request. A chain-cut control forces the chain output low. On an acknowledge pulse, the one requesting source is marked under-service and its 8-bit vector is presented for one cycle. A per-source control can replace the low vector bits with a condition code. A no-vector control suppresses the presentation. A soft reset input returns every flag to its reset value.

Top module: `isc_ctrl`

## Requirements
- R1: After reset, every status byte is 0, `irq_o` and `vec_valid_o` are 0, and `chain_out_o` follows `chain_in_i`.
- R2: A write to source `cmd_sel` applies the command in `cmd_wdata[7:5]` at the next clock edge, with these codes:
  - 1 clears both pending and under-service.
  - 2 sets under-service.
  - 3 clears under-service.
  - 4 sets pending.
  - 5 clears pending.
  - 6 sets enable.
  - 7 clears enable.
- R3: The status byte of source k is `stat_o[8k+7:8k]`. It holds under-service at bit 7, enable at bit 6, pending at bit 5 and error at bit 4. Bits 3:0 read 0.
- R4: An event pulse sets pending. If pending was already 1, the event also sets error. Commands 1 and 5 clear error together with pending.
- R5: A source requests when pending, enable and `mie_i` are 1, under-service is 0, and its chain input is 1. `irq_o` is the registered OR of all requests and follows one cycle later.
- R6: Under-service or an active request in a source holds the chain input of every lower-priority source at 0, so at most one source requests at a time.
- R7: While `dlc_i` is 1, `chain_out_o` is 0.
- R8: An `ack_i` pulse sets under-service in the requesting source. In the following cycle `vec_valid_o` is 1 for exactly one cycle, and `vec_o` holds that source's vector base.
- R9: While `nv_i` is 1, an acknowledge still sets under-service but `vec_valid_o` stays 0.
- R10: When `vis_i[k]` is 1, the low COND_W bits of the vector of source k are replaced by `cond_i[k]`.
- R11: `srst_i` clears every flag of every source at the next edge.
- R12: Command 0 changes no flag, whatever the value of bits 4:0. A write changes only the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command/status write strobe |
| cmd_sel | input | $clog2(NSRC) | Source addressed by the write |
| cmd_wdata | input | 8 | Write byte; command in bits 7:5 |
| evt_i | input | NSRC | Raw event pulses, one per source |
| mie_i | input | 1 | Master interrupt enable |
| srst_i | input | 1 | Soft reset of all flags |
| dlc_i | input | 1 | Forces chain output low |
| nv_i | input | 1 | Suppresses vector presentation |
| vis_i | input | NSRC | Vector includes condition code, per source |
| chain_in_i | input | 1 | Daisy-chain enable from higher priority |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| vec_base_i | input | 8*NSRC | Vector base bytes, source k at [8k+7:8k] |
| cond_i | input | COND_W*NSRC | Condition codes, per source |
| stat_o | output | 8*NSRC | Status bytes, per source |
| irq_o | output | 1 | Registered interrupt request |
| chain_out_o | output | 1 | Daisy-chain enable to lower priority |
| vec_valid_o | output | 1 | Vector presented this cycle |
| vec_o | output | 8 | Acknowledged vector |

## Verification
Every flag shows directly in the status bytes. A wrong flag transition therefore appears at `stat_o` at the first sampling point after the edge that applied a command or event. A gating fault in the chain shows at once on `chain_out_o`. The same fault shows one cycle later on `irq_o`, either as a request that should be blocked or as a missing request. An acknowledge that picks the wrong source, or mixes up vector bits, shows on `vec_o` in the cycle after the pulse. That source's status byte also shows under-service set.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CLR_BOTH = 3'd1,
    CMD_SET_SVC  = 3'd2,
    CMD_CLR_SVC  = 3'd3,
    CMD_SET_PEND = 3'd4,
    CMD_CLR_PEND = 3'd5,
    CMD_SET_EN   = 3'd6,
    CMD_CLR_EN   = 3'd7
  } cmd_e;

  // Field order gives the status byte layout: svc=7, en=6, pend=5, err=4
  typedef struct packed {
    logic svc;
    logic en;
    logic pend;
    logic err;
  } flags_t;

  localparam int CMD_LSB = 5;

  function automatic logic [7:0] status_byte(flags_t f);
    return {f, 4'b0000};
  endfunction

endpackage

// File: rtl/isc_src.sv
module isc_src
  import isc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   srst,
  input  logic   wr_hit,
  input  cmd_e   cmd,
  input  logic   evt,
  input  logic   ack_set,
  output flags_t flags
);

  flags_t nxt;

  always_comb begin
    nxt = flags;
    if (wr_hit) begin
      unique case (cmd)
        CMD_CLR_BOTH: begin nxt.pend = 1'b0; nxt.svc = 1'b0; nxt.err = 1'b0; end
        CMD_SET_SVC:  nxt.svc  = 1'b1;
        CMD_CLR_SVC:  nxt.svc  = 1'b0;
        CMD_SET_PEND: nxt.pend = 1'b1;
        CMD_CLR_PEND: begin nxt.pend = 1'b0; nxt.err = 1'b0; end
        CMD_SET_EN:   nxt.en   = 1'b1;
        CMD_CLR_EN:   nxt.en   = 1'b0;
        default:      ;
      endcase
    end
    // event judged on the flag state before this edge
    if (evt) begin
      nxt.err  = nxt.err | flags.pend;
      nxt.pend = 1'b1;
    end
    if (ack_set) nxt.svc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || srst) flags <= '0;
    else             flags <= nxt;
  end

  p_err_origin_r4: assert property (@(posedge clk) disable iff (rst || srst)
    $rose(flags.err) |-> $past(flags.pend));
  p_set_en_r2: assert property (@(posedge clk) disable iff (rst || srst)
    (wr_hit && cmd == CMD_SET_EN) |=> flags.en);
  p_clr_en_r2: assert property (@(posedge clk) disable iff (rst || srst)
    (wr_hit && cmd == CMD_CLR_EN) |=> !flags.en);
  p_evt_pend_r4: assert property (@(posedge clk) disable iff (rst || srst)
    evt |=> flags.pend);
  p_nop_r12: assert property (@(posedge clk) disable iff (rst || srst)
    (wr_hit && cmd == CMD_NOP && !evt && !ack_set) |=> $stable(flags));
  p_ack_svc_r8: assert property (@(posedge clk) disable iff (rst || srst)
    ack_set |=> flags.svc);

endmodule

// File: rtl/isc_daisy.sv
module isc_daisy
  import isc_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  flags_t          fl [NSRC],
  input  logic            mie,
  input  logic            chain_in,
  input  logic            dlc,
  output logic [NSRC-1:0] req,
  output logic            chain_out
);

  logic [NSRC:0] ei;

  assign ei[0] = chain_in;

  for (genvar k = 0; k < NSRC; k++) begin : g_link
    assign req[k]  = fl[k].pend & fl[k].en & mie & ~fl[k].svc & ei[k];
    assign ei[k+1] = ei[k] & ~fl[k].svc & ~req[k];

    p_svc_blocks_r6: assert property (@(posedge clk) disable iff (rst)
      fl[k].svc |-> !ei[k+1]);
  end

  assign chain_out = ei[NSRC] & ~dlc;

  p_one_req_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req));
  p_cut_r7: assert property (@(posedge clk) disable iff (rst)
    dlc |-> !chain_out);
  p_req_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> !chain_out);

endmodule

// File: rtl/isc_vec.sv
module isc_vec #(
  parameter int NSRC   = 3,
  parameter int COND_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   srst,
  input  logic                   ack,
  input  logic [NSRC-1:0]        req,
  input  logic                   nv,
  input  logic [NSRC-1:0]        vis,
  input  logic [NSRC*COND_W-1:0] cond,
  input  logic [NSRC*8-1:0]      base,
  output logic [NSRC-1:0]        ack_hit,
  output logic                   vec_valid,
  output logic [7:0]             vec
);

  logic [7:0] cand [NSRC];
  logic [7:0] pick;

  for (genvar k = 0; k < NSRC; k++) begin : g_cand
    always_comb begin
      cand[k] = base[k*8 +: 8];
      if (vis[k]) cand[k][COND_W-1:0] = cond[k*COND_W +: COND_W];
    end
  end

  assign ack_hit = {NSRC{ack}} & req;

  // requests are one-hot by chain construction, so an OR merge suffices
  always_comb begin
    pick = '0;
    for (int k = 0; k < NSRC; k++)
      if (req[k]) pick = pick | cand[k];
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= ack & (|req) & ~nv;
      if (ack && (|req)) vec <= pick;
    end
  end

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst || srst)
    vec_valid |=> !vec_valid);
  p_nv_r9: assert property (@(posedge clk) disable iff (rst || srst)
    vec_valid |-> !$past(nv));
  p_ack_needed_r8: assert property (@(posedge clk) disable iff (rst || srst)
    vec_valid |-> $past(ack));

endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int COND_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_we,
  input  logic [$clog2(NSRC)-1:0]   cmd_sel,
  input  logic [7:0]                cmd_wdata,
  input  logic [NSRC-1:0]           evt_i,
  input  logic                      mie_i,
  input  logic                      srst_i,
  input  logic                      dlc_i,
  input  logic                      nv_i,
  input  logic [NSRC-1:0]           vis_i,
  input  logic                      chain_in_i,
  input  logic                      ack_i,
  input  logic [NSRC*8-1:0]         vec_base_i,
  input  logic [NSRC*COND_W-1:0]    cond_i,
  output logic [NSRC*8-1:0]         stat_o,
  output logic                      irq_o,
  output logic                      chain_out_o,
  output logic                      vec_valid_o,
  output logic [7:0]                vec_o
);

  localparam int SEL_W = $clog2(NSRC);

  cmd_e            cmd;
  flags_t          fl [NSRC];
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] ack_hit;
  logic [NSRC-1:0] wr_hit;

  assign cmd = cmd_e'(cmd_wdata[CMD_LSB +: 3]);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign wr_hit[k] = cmd_we && (cmd_sel == SEL_W'(k));

    isc_src u_src (
      .clk     (clk),
      .rst     (rst),
      .srst    (srst_i),
      .wr_hit  (wr_hit[k]),
      .cmd     (cmd),
      .evt     (evt_i[k]),
      .ack_set (ack_hit[k]),
      .flags   (fl[k])
    );

    assign stat_o[k*8 +: 8] = status_byte(fl[k]);
  end

  isc_daisy #(.NSRC(NSRC)) u_daisy (
    .clk       (clk),
    .rst       (rst),
    .fl        (fl),
    .mie       (mie_i),
    .chain_in  (chain_in_i),
    .dlc       (dlc_i),
    .req       (req),
    .chain_out (chain_out_o)
  );

  isc_vec #(.NSRC(NSRC), .COND_W(COND_W)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .srst      (srst_i),
    .ack       (ack_i),
    .req       (req),
    .nv        (nv_i),
    .vis       (vis_i),
    .cond      (cond_i),
    .base      (vec_base_i),
    .ack_hit   (ack_hit),
    .vec_valid (vec_valid_o),
    .vec       (vec_o)
  );

  always_ff @(posedge clk) begin
    if (rst || srst_i) irq_o <= 1'b0;
    else               irq_o <= |req;
  end

  p_irq_mie_r5: assert property (@(posedge clk) disable iff (rst || srst_i)
    irq_o |-> $past(mie_i));
  p_nop_lowbits_r12: assert property (@(posedge clk) disable iff (rst || srst_i)
    (cmd_we && cmd_wdata[7:5] == 3'd0 && cmd_wdata[4:0] != 5'd0 && evt_i == '0 && !ack_i)
    |=> $stable(stat_o));

endmodule

// File: tb/sim_isc_ctrl.sv
module sim_isc_ctrl;

  localparam int NSRC = 3;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 1'b0;
  logic [1:0] cmd_sel = '0;
  logic [7:0] cmd_wdata = '0;
  logic [NSRC-1:0] evt_i = '0;
  logic mie_i = 1'b0, srst_i = 1'b0, dlc_i = 1'b0, nv_i = 1'b0;
  logic [NSRC-1:0] vis_i = '0;
  logic chain_in_i = 1'b1, ack_i = 1'b0;
  logic [NSRC*8-1:0] vec_base_i = {8'hA8, 8'h90, 8'h70};
  logic [NSRC*CW-1:0] cond_i = {3'b101, 3'b011, 3'b110};
  logic [NSRC*8-1:0] stat_o;
  logic irq_o, chain_out_o, vec_valid_o;
  logic [7:0] vec_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  isc_ctrl #(.NSRC(NSRC), .COND_W(CW)) u0 (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
    .evt_i(evt_i), .mie_i(mie_i), .srst_i(srst_i), .dlc_i(dlc_i), .nv_i(nv_i),
    .vis_i(vis_i), .chain_in_i(chain_in_i), .ack_i(ack_i), .vec_base_i(vec_base_i),
    .cond_i(cond_i), .stat_o(stat_o), .irq_o(irq_o), .chain_out_o(chain_out_o),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input int k);
    return stat_o[k*8 +: 8];
  endfunction

  task automatic wr(input int k, input logic [2:0] c, input logic [4:0] low = 5'd0);
    cmd_we = 1'b1; cmd_sel = 2'(k); cmd_wdata = {c, low};
    @(negedge clk);
    cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic pulse_evt(input int k);
    evt_i[k] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic pulse_ack;
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 stat", 32'(stat_o), 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 vec_valid", 32'(vec_valid_o), 32'h0);
    chk("R1 chain_out", 32'(chain_out_o), 32'h1);
  endtask

  task automatic t_cmds;
    wr(1, 3'd6); chk("R2 set en", 32'(st(1)), 32'h40);
    wr(1, 3'd4); chk("R2 set pend", 32'(st(1)), 32'h60);
    wr(1, 3'd2); chk("R3 set svc layout", 32'(st(1)), 32'hE0);
    wr(1, 3'd0, 5'h1F); chk("R12 null keeps flags", 32'(st(1)), 32'hE0);
    chk("R12 other sources untouched", 32'({st(2), st(0)}), 32'h0);
    wr(1, 3'd3); chk("R2 clr svc", 32'(st(1)), 32'h60);
    wr(1, 3'd5); chk("R2 clr pend", 32'(st(1)), 32'h40);
    wr(1, 3'd4); wr(1, 3'd2); wr(1, 3'd1);
    chk("R2 clr both", 32'(st(1)), 32'h40);
    wr(1, 3'd7); chk("R2 clr en", 32'(st(1)), 32'h00);
  endtask

  task automatic t_event;
    pulse_evt(2); chk("R4 event sets pend", 32'(st(2)), 32'h20);
    pulse_evt(2); chk("R4 second event sets err", 32'(st(2)), 32'h30);
    wr(2, 3'd5); chk("R4 clr pend clears err", 32'(st(2)), 32'h00);
    pulse_evt(2); pulse_evt(2);
    wr(2, 3'd1); chk("R4 clr both clears err", 32'(st(2)), 32'h00);
  endtask

  task automatic t_req;
    mie_i = 1'b1;
    wr(0, 3'd6); pulse_evt(0);
    @(negedge clk); chk("R5 irq follows request", 32'(irq_o), 32'h1);
    mie_i = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 master enable gates irq", 32'(irq_o), 32'h0);
    mie_i = 1'b1; chain_in_i = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 chain input gates irq", 32'(irq_o), 32'h0);
    chain_in_i = 1'b1; @(negedge clk); @(negedge clk);
    chk("R5 irq returns", 32'(irq_o), 32'h1);
  endtask

  task automatic t_chain_ack;
    // source 0 requesting from t_req
    chk("R6 request blocks chain", 32'(chain_out_o), 32'h0);
    wr(2, 3'd6); pulse_evt(2);
    pulse_ack;
    chk("R8 vec valid", 32'(vec_valid_o), 32'h1);
    chk("R8 vec source 0", 32'(vec_o), 32'h70);
    @(negedge clk);
    chk("R8 valid one cycle", 32'(vec_valid_o), 32'h0);
    chk("R8 svc set", 32'(st(0)), 32'hE0);
    chk("R6 svc blocks lower source", 32'(irq_o), 32'h0);
    chk("R6 svc blocks chain", 32'(chain_out_o), 32'h0);
    vis_i[2] = 1'b1;
    wr(0, 3'd1);
    pulse_ack;
    chk("R10 status in vector", 32'(vec_o), 32'hAD);
    chk("R8 svc on source 2", 32'(st(2)), 32'hE0);
    vis_i = '0;
    wr(2, 3'd1); wr(2, 3'd7); wr(0, 3'd7);
    chk("R6 chain open when idle", 32'(chain_out_o), 32'h1);
    dlc_i = 1'b1; #1;
    chk("R7 cut forces chain low", 32'(chain_out_o), 32'h0);
    dlc_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_nv;
    nv_i = 1'b1;
    wr(1, 3'd6); pulse_evt(1);
    pulse_ack;
    chk("R9 no vector presented", 32'(vec_valid_o), 32'h0);
    chk("R9 svc still set", 32'(st(1)), 32'hE0);
    nv_i = 1'b0;
  endtask

  task automatic t_srst;
    wr(0, 3'd6); wr(2, 3'd4);
    srst_i = 1'b1; @(negedge clk); srst_i = 1'b0;
    chk("R11 soft reset clears flags", 32'(stat_o), 32'h0);
    chk("R11 irq clear", 32'(irq_o), 32'h0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cmds();
    t_event();
    t_req();
    t_chain_ack();
    t_nv();
    t_srst();
    finish_run();
  end

endmodule